// File: doc/BRIEF.md
# SIMT Divergence Stack

This block holds the divergence state of a single SIMT wavefront. Each stack entry carries a program counter, the reconvergence PC at which the divergent path rejoins, and a per-lane execution mask. The current PC, reconvergence PC and active mask presented to the rest of the pipeline always come from the top entry. An empty stack presents zeros on all three.

Branch logic pushes a new entry when lanes diverge, and overwrites the top PC when a branch is taken. The issue stage reports each retired instruction, together with a flag that says whether that instruction changed the PC. When the PC did not change, the block advances the top PC by one. If the advanced value equals the top reconvergence PC, the entry is popped instead, and the block asks for the instruction buffer to be flushed. If a fetch is still outstanding at that moment, the block also marks that fetch so that its returning data is dropped. Otherwise the block only signals that the retired instruction leaves the buffer.

Illegal requests leave the stack unchanged and raise a one-cycle error flag. These are a push with no active lane, a push onto a full stack, and a pop, retire or PC write on an empty stack.

Top module: `simt_div_stack`

## Requirements
- R1: `cur_pc`, `cur_rpc` and `cur_mask` show the fields of the most recently pushed entry that is still on the stack. While the stack is empty, all three read zero.
- R2: `active_lanes` always equals the number of set bits in `cur_mask`.
- R3: A retire with `retire_pc_modified`=0 whose advanced PC (top PC + 1, modulo 2^PC_W) differs from `cur_rpc` writes that value into the top PC. `dequeue` is then high for exactly the cycle after the retire.
- R4: A retire with `retire_pc_modified`=0 whose advanced PC equals `cur_rpc` pops the top entry and raises `flush_ibuf` in the next cycle. The advance wraps, so a PC of all ones reaches a reconvergence PC of zero. `dequeue` stays low in that case.
- R5: `drop_fetch` is high together with `flush_ibuf` exactly when `fetch_pending` was high during the popping retire.
- R6: A push whose `push_mask` is zero leaves the stack unchanged and sets `err_zero_mask` for one cycle.
- R7: A PC write replaces only the top PC with `pcwr_pc`. `cur_rpc` and `cur_mask` stay as they were.
- R8: A push onto a stack already holding DEPTH entries leaves the stack unchanged and sets `err_overflow` for one cycle.
- R9: A retire or a PC write on an empty stack changes nothing and sets `err_underflow` for one cycle.
- R10: A retire with `retire_pc_modified`=1 changes no state and raises no strobe.
- R11: When several requests come in the same cycle, only one is acted on, in the order push, then PC write, then retire. The requests that lose are ignored.
- R12: An asserted `rst_n` empties the stack and clears every strobe and error flag.
- R13: Every strobe and error output is registered. It appears in the cycle after the request that caused it and lasts one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_valid | input | 1 | Push a new entry |
| push_pc | input | PC_W | PC of the pushed entry |
| push_rpc | input | PC_W | Reconvergence PC of the pushed entry |
| push_mask | input | LANES | Lane mask of the pushed entry |
| pcwr_valid | input | 1 | Taken-branch write of the top PC |
| pcwr_pc | input | PC_W | New top PC |
| retire_valid | input | 1 | An instruction retired |
| retire_pc_modified | input | 1 | The retired instruction changed the PC |
| fetch_pending | input | 1 | An instruction fetch is outstanding |
| cur_pc | output | PC_W | Top PC |
| cur_rpc | output | PC_W | Top reconvergence PC |
| cur_mask | output | LANES | Top lane mask |
| active_lanes | output | clog2(LANES+1) | Set bits in the top mask |
| flush_ibuf | output | 1 | Flush the instruction buffer |
| drop_fetch | output | 1 | Discard the outstanding fetch |
| dequeue | output | 1 | Remove the retired instruction from the buffer |
| err_zero_mask | output | 1 | A push with an empty mask was rejected |
| err_overflow | output | 1 | A push onto a full stack was rejected |
| err_underflow | output | 1 | A retire or PC write on an empty stack was rejected |

## Verification
The bench builds the block with DEPTH=3, LANES=8 and PC_W=8. The shallow depth lets a short sequence fill the stack and reach the overflow path. With eight-bit PCs, a top PC of 255 can advance to a reconvergence PC of 0, which exercises the wrapping pop. Eight lanes keep the population counts small enough to cover the single-lane, partial and full masks.

// File: rtl/simt_stack_pkg.sv
package simt_stack_pkg;
  typedef enum logic [1:0] {
    ACT_NONE   = 2'd0,
    ACT_PUSH   = 2'd1,
    ACT_SETPC  = 2'd2,
    ACT_RETIRE = 2'd3
  } stk_act_e;
endpackage

// File: rtl/stk_popcnt.sv
module stk_popcnt #(
  parameter int LANES = 8,
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic [LANES-1:0] mask,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] part [LANES+1];
  assign part[0] = '0;
  for (genvar g = 0; g < LANES; g++) begin : g_sum
    assign part[g+1] = part[g] + CNT_W'(mask[g]);
  end
  assign count = part[LANES];
endmodule

// File: rtl/stk_entries.sv
module stk_entries #(
  parameter int PC_W  = 16,
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LVL_W-1:0] lvl,
  input  logic             push_we,
  input  logic [PC_W-1:0]  push_pc,
  input  logic [PC_W-1:0]  push_rpc,
  input  logic [LANES-1:0] push_mask,
  input  logic             setpc_we,
  input  logic [PC_W-1:0]  setpc_val,
  output logic [PC_W-1:0]  top_pc,
  output logic [PC_W-1:0]  top_rpc,
  output logic [LANES-1:0] top_mask
);
  logic [PC_W-1:0]  pc_q   [DEPTH];
  logic [PC_W-1:0]  rpc_q  [DEPTH];
  logic [LANES-1:0] mask_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_ent
    logic fill_en, pc_en;
    logic [PC_W-1:0] pc_d;
    // a push fills slot lvl; a PC write targets slot lvl-1
    assign fill_en = push_we && (lvl == LVL_W'(i));
    assign pc_en   = fill_en || (setpc_we && (lvl == LVL_W'(i + 1)));
    assign pc_d    = fill_en ? push_pc : setpc_val;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        pc_q[i]   <= '0;
        rpc_q[i]  <= '0;
        mask_q[i] <= '0;
      end else begin
        if (pc_en) pc_q[i] <= pc_d;
        if (fill_en) begin
          rpc_q[i]  <= push_rpc;
          mask_q[i] <= push_mask;
        end
      end
    end
  end

  always_comb begin
    top_pc   = '0;
    top_rpc  = '0;
    top_mask = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (lvl == LVL_W'(i + 1)) begin
        top_pc   = pc_q[i];
        top_rpc  = rpc_q[i];
        top_mask = mask_q[i];
      end
    end
  end
endmodule

// File: rtl/stk_ctrl.sv
module stk_ctrl
  import simt_stack_pkg::*;
#(
  parameter int PC_W  = 16,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic             push_nz,
  input  logic             pcwr_valid,
  input  logic [PC_W-1:0]  pcwr_pc,
  input  logic             retire_valid,
  input  logic             retire_pc_modified,
  input  logic             fetch_pending,
  input  logic [PC_W-1:0]  top_pc,
  input  logic [PC_W-1:0]  top_rpc,
  output logic [LVL_W-1:0] lvl,
  output logic             push_we,
  output logic             setpc_we,
  output logic [PC_W-1:0]  setpc_val,
  output logic             flush_ibuf,
  output logic             drop_fetch,
  output logic             dequeue,
  output logic             err_zero_mask,
  output logic             err_overflow,
  output logic             err_underflow
);
  stk_act_e         act;
  logic             empty, full, lvl_en;
  logic [LVL_W-1:0] lvl_d;
  logic [PC_W-1:0]  adv_pc;
  logic             flush_d, drop_d, deq_d, ez_d, ov_d, un_d;

  assign empty  = (lvl == '0);
  assign full   = (lvl == LVL_W'(DEPTH));
  assign adv_pc = top_pc + 1'b1;

  always_comb begin
    if (push_valid)        act = ACT_PUSH;
    else if (pcwr_valid)   act = ACT_SETPC;
    else if (retire_valid) act = ACT_RETIRE;
    else                   act = ACT_NONE;
  end

  always_comb begin
    lvl_en    = 1'b0;
    lvl_d     = lvl;
    push_we   = 1'b0;
    setpc_we  = 1'b0;
    setpc_val = pcwr_pc;
    flush_d   = 1'b0;
    drop_d    = 1'b0;
    deq_d     = 1'b0;
    ez_d      = 1'b0;
    ov_d      = 1'b0;
    un_d      = 1'b0;
    unique case (act)
      ACT_PUSH: begin
        if (!push_nz)   ez_d = 1'b1;
        else if (full)  ov_d = 1'b1;
        else begin
          push_we = 1'b1;
          lvl_en  = 1'b1;
          lvl_d   = lvl + 1'b1;
        end
      end
      ACT_SETPC: begin
        if (empty) un_d = 1'b1;
        else       setpc_we = 1'b1;
      end
      ACT_RETIRE: begin
        if (empty) un_d = 1'b1;
        else if (!retire_pc_modified) begin
          if (adv_pc == top_rpc) begin
            lvl_en  = 1'b1;
            lvl_d   = lvl - 1'b1;
            flush_d = 1'b1;
            drop_d  = fetch_pending;
          end else begin
            setpc_we  = 1'b1;
            setpc_val = adv_pc;
            deq_d     = 1'b1;
          end
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lvl           <= '0;
      flush_ibuf    <= 1'b0;
      drop_fetch    <= 1'b0;
      dequeue       <= 1'b0;
      err_zero_mask <= 1'b0;
      err_overflow  <= 1'b0;
      err_underflow <= 1'b0;
    end else begin
      if (lvl_en) lvl <= lvl_d;
      flush_ibuf    <= flush_d;
      drop_fetch    <= drop_d;
      dequeue       <= deq_d;
      err_zero_mask <= ez_d;
      err_overflow  <= ov_d;
      err_underflow <= un_d;
    end
  end
endmodule

// File: rtl/simt_div_stack.sv
module simt_div_stack #(
  parameter int PC_W  = 16,
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             push_valid,
  input  logic [PC_W-1:0]  push_pc,
  input  logic [PC_W-1:0]  push_rpc,
  input  logic [LANES-1:0] push_mask,
  input  logic             pcwr_valid,
  input  logic [PC_W-1:0]  pcwr_pc,
  input  logic             retire_valid,
  input  logic             retire_pc_modified,
  input  logic             fetch_pending,
  output logic [PC_W-1:0]  cur_pc,
  output logic [PC_W-1:0]  cur_rpc,
  output logic [LANES-1:0] cur_mask,
  output logic [CNT_W-1:0] active_lanes,
  output logic             flush_ibuf,
  output logic             drop_fetch,
  output logic             dequeue,
  output logic             err_zero_mask,
  output logic             err_overflow,
  output logic             err_underflow
);
  logic [LVL_W-1:0] lvl;
  logic             push_we, setpc_we;
  logic [PC_W-1:0]  setpc_val;

  stk_ctrl #(.PC_W(PC_W), .DEPTH(DEPTH)) u_ctrl (
    .clk                (clk),
    .rst_n              (rst_n),
    .push_valid         (push_valid),
    .push_nz            (|push_mask),
    .pcwr_valid         (pcwr_valid),
    .pcwr_pc            (pcwr_pc),
    .retire_valid       (retire_valid),
    .retire_pc_modified (retire_pc_modified),
    .fetch_pending      (fetch_pending),
    .top_pc             (cur_pc),
    .top_rpc            (cur_rpc),
    .lvl                (lvl),
    .push_we            (push_we),
    .setpc_we           (setpc_we),
    .setpc_val          (setpc_val),
    .flush_ibuf         (flush_ibuf),
    .drop_fetch         (drop_fetch),
    .dequeue            (dequeue),
    .err_zero_mask      (err_zero_mask),
    .err_overflow       (err_overflow),
    .err_underflow      (err_underflow)
  );

  stk_entries #(.PC_W(PC_W), .LANES(LANES), .DEPTH(DEPTH)) u_ent (
    .clk       (clk),
    .rst_n     (rst_n),
    .lvl       (lvl),
    .push_we   (push_we),
    .push_pc   (push_pc),
    .push_rpc  (push_rpc),
    .push_mask (push_mask),
    .setpc_we  (setpc_we),
    .setpc_val (setpc_val),
    .top_pc    (cur_pc),
    .top_rpc   (cur_rpc),
    .top_mask  (cur_mask)
  );

  stk_popcnt #(.LANES(LANES)) u_cnt (
    .mask  (cur_mask),
    .count (active_lanes)
  );
endmodule

// File: rtl/stk_checker.sv
module stk_checker #(
  parameter int PC_W  = 16,
  parameter int LANES = 8,
  parameter int DEPTH = 4,
  localparam int LVL_W = $clog2(DEPTH + 1),
  localparam int CNT_W = $clog2(LANES + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             push_valid,
  input logic [LANES-1:0] push_mask,
  input logic             pcwr_valid,
  input logic [PC_W-1:0]  pcwr_pc,
  input logic             retire_valid,
  input logic             retire_pc_modified,
  input logic [PC_W-1:0]  cur_pc,
  input logic [PC_W-1:0]  cur_rpc,
  input logic [LANES-1:0] cur_mask,
  input logic [CNT_W-1:0] active_lanes,
  input logic             flush_ibuf,
  input logic             drop_fetch,
  input logic             dequeue,
  input logic             err_zero_mask,
  input logic             err_overflow,
  input logic             err_underflow,
  input logic [LVL_W-1:0] lvl
);
  logic [PC_W-1:0] nxt;
  logic            plain_ret, has_top;
  assign nxt       = cur_pc + 1'b1;
  assign has_top   = (lvl != '0);
  assign plain_ret = retire_valid && !push_valid && !pcwr_valid && has_top;

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !has_top |-> (cur_mask == '0 && cur_pc == '0)); // R1
  AST_LANE_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    active_lanes == CNT_W'($countones(cur_mask))); // R2
  AST_ADVANCE: assert property (@(posedge clk) disable iff (!rst_n)
    plain_ret && !retire_pc_modified && nxt != cur_rpc |=> cur_pc == $past(nxt) && dequeue); // R3
  AST_POP_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    plain_ret && !retire_pc_modified && nxt == cur_rpc |=> flush_ibuf && !dequeue); // R4
  AST_DROP_WITH_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    drop_fetch |-> flush_ibuf); // R5
  AST_ZERO_MASK: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_mask == '0 |=> err_zero_mask && $stable(lvl)); // R6
  AST_PCWR_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    pcwr_valid && !push_valid && has_top |=> cur_pc == $past(pcwr_pc) && $stable(cur_rpc) && $stable(cur_mask)); // R7
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    push_valid && push_mask != '0 && lvl == LVL_W'(DEPTH) |=> err_overflow && $stable(lvl)); // R8
  AST_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !push_valid && !has_top && (pcwr_valid || retire_valid) |=> err_underflow); // R9
  AST_MODIFIED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    plain_ret && retire_pc_modified |=> $stable(cur_pc) && $stable(lvl) && !dequeue && !flush_ibuf); // R10
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flush_ibuf, dequeue, err_zero_mask, err_overflow, err_underflow})); // R11
endmodule

bind simt_div_stack stk_checker #(.PC_W(PC_W), .LANES(LANES), .DEPTH(DEPTH)) u_chk (.*);

// File: tb/tb_simt_div_stack.sv
module tb_simt_div_stack;
  localparam int PC_W = 8, LANES = 8, DEPTH = 3, NROW = 25;

  logic clk, rst_n;
  logic push_valid, pcwr_valid, retire_valid, retire_pc_modified, fetch_pending;
  logic [7:0] push_pc, push_rpc, push_mask, pcwr_pc;
  logic [7:0] cur_pc, cur_rpc, cur_mask;
  logic [3:0] active_lanes;
  logic flush_ibuf, drop_fetch, dequeue, err_zero_mask, err_overflow, err_underflow;
  int checks = 0, fails = 0;

  simt_div_stack #(.PC_W(PC_W), .LANES(LANES), .DEPTH(DEPTH)) dut (.*);

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // strobes {flush, drop, deq, err_zero, err_ovf, err_unf}
  typedef struct packed {
    logic pv; logic [7:0] ppc, prpc, pmask;
    logic wv; logic [7:0] wpc;
    logic rv, rmod, fp;
    logic [7:0] epc, erpc, emask; logic [3:0] eact; logic [5:0] estb;
    logic [3:0] req;
  } row_t;

  localparam row_t TBL [NROW] = '{
    '{1'b1, 8'd10, 8'd50, 8'hFF, 1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 8'd10, 8'd50, 8'hFF, 4'd8, 6'b000000, 4'd1},  // R1
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd11, 8'd50, 8'hFF, 4'd8, 6'b001000, 4'd3},  // R3
    '{1'b1, 8'd20, 8'd23, 8'h0F, 1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 8'd20, 8'd23, 8'h0F, 4'd4, 6'b000000, 4'd2},  // R2
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd21, 8'd23, 8'h0F, 4'd4, 6'b001000, 4'd3},  // R3
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b1, 8'd22, 1'b0, 1'b0, 1'b0, 8'd22, 8'd23, 8'h0F, 4'd4, 6'b000000, 4'd7},  // R7
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b1, 1'b0, 8'd22, 8'd23, 8'h0F, 4'd4, 6'b000000, 4'd10}, // R10
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 8'd11, 8'd50, 8'hFF, 4'd8, 6'b110000, 4'd5},  // R5
    '{1'b1, 8'd40, 8'd41, 8'h00, 1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 8'd11, 8'd50, 8'hFF, 4'd8, 6'b000100, 4'd6},  // R6
    '{1'b1, 8'd30, 8'd32, 8'hA5, 1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 8'd30, 8'd32, 8'hA5, 4'd4, 6'b000000, 4'd2},  // R2
    '{1'b1, 8'd40, 8'd41, 8'h01, 1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 8'd40, 8'd41, 8'h01, 4'd1, 6'b000000, 4'd1},  // R1
    '{1'b1, 8'd60, 8'd61, 8'hFF, 1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 8'd40, 8'd41, 8'h01, 4'd1, 6'b000010, 4'd8},  // R8
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd30, 8'd32, 8'hA5, 4'd4, 6'b100000, 4'd4},  // R4
    '{1'b1, 8'd70, 8'd72, 8'h03, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd70, 8'd72, 8'h03, 4'd2, 6'b000000, 4'd11}, // R11
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b1, 8'd90, 1'b1, 1'b0, 1'b0, 8'd90, 8'd72, 8'h03, 4'd2, 6'b000000, 4'd11}, // R11
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd91, 8'd72, 8'h03, 4'd2, 6'b001000, 4'd3},  // R3
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b1, 8'd71, 1'b0, 1'b0, 1'b0, 8'd71, 8'd72, 8'h03, 4'd2, 6'b000000, 4'd7},  // R7
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd30, 8'd32, 8'hA5, 4'd4, 6'b100000, 4'd4},  // R4
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd31, 8'd32, 8'hA5, 4'd4, 6'b001000, 4'd3},  // R3
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd11, 8'd50, 8'hFF, 4'd8, 6'b100000, 4'd4},  // R4
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b1, 8'd49, 1'b0, 1'b0, 1'b0, 8'd49, 8'd50, 8'hFF, 4'd8, 6'b000000, 4'd7},  // R7
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  8'd0,  8'h00, 4'd0, 6'b100000, 4'd4},  // R4
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b0, 8'd0,  8'd0,  8'h00, 4'd0, 6'b000001, 4'd9},  // R9
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b1, 8'd5,  1'b0, 1'b0, 1'b0, 8'd0,  8'd0,  8'h00, 4'd0, 6'b000001, 4'd9},  // R9
    '{1'b1, 8'd255,8'd0,  8'h80, 1'b0, 8'd0,  1'b0, 1'b0, 1'b0, 8'd255,8'd0,  8'h80, 4'd1, 6'b000000, 4'd2},  // R2
    '{1'b0, 8'd0,  8'd0,  8'h00, 1'b0, 8'd0,  1'b1, 1'b0, 1'b1, 8'd0,  8'd0,  8'h00, 4'd0, 6'b110000, 4'd4}   // R4
  };

  function automatic logic [37:0] observed();
    return {cur_pc, cur_rpc, cur_mask, active_lanes,
            flush_ibuf, drop_fetch, dequeue, err_zero_mask, err_overflow, err_underflow};
  endfunction

  task automatic check(input logic [37:0] exp, input int req, input string what);
    checks++;
    if (observed() !== exp) begin
      fails++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, observed(), exp);
    end
  endtask

  task automatic idle_inputs();
    push_valid = 0; push_pc = 0; push_rpc = 0; push_mask = 0;
    pcwr_valid = 0; pcwr_pc = 0; retire_valid = 0; retire_pc_modified = 0;
    fetch_pending = 0;
  endtask

  task automatic summary();
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL R12 watchdog: actual=hung expected=finished");
    summary();
    $finish;
  end

  initial begin
    idle_inputs();
    rst_n = 0;
    repeat (2) @(negedge clk);
    check(38'h0, 12, "reset state");                      // r12_
    rst_n = 1;
    @(negedge clk);
    check(38'h0, 1, "empty after reset");                 // R1
    for (int i = 0; i < NROW; i++) begin
      push_valid = TBL[i].pv; push_pc = TBL[i].ppc; push_rpc = TBL[i].prpc;
      push_mask = TBL[i].pmask; pcwr_valid = TBL[i].wv; pcwr_pc = TBL[i].wpc;
      retire_valid = TBL[i].rv; retire_pc_modified = TBL[i].rmod;
      fetch_pending = TBL[i].fp;
      @(negedge clk);
      idle_inputs();
      check({TBL[i].epc, TBL[i].erpc, TBL[i].emask, TBL[i].eact, TBL[i].estb},
            int'(TBL[i].req), $sformatf("row %0d", i));
    end
    // R13: strobes last one cycle only
    @(negedge clk);
    check(38'h0, 13, "strobe cleared after one cycle");
    // R12: reset in the middle of operation
    push_valid = 1; push_pc = 8'd5; push_rpc = 8'd9; push_mask = 8'h0F;
    @(negedge clk);
    idle_inputs();
    check({8'd5, 8'd9, 8'h0F, 4'd4, 6'b0}, 1, "push before reset");
    retire_valid = 1;
    #1 rst_n = 0;
    #1;
    check(38'h0, 12, "asynchronous reset clears stack");
    @(negedge clk);
    idle_inputs();
    rst_n = 1;
    @(negedge clk);
    check(38'h0, 12, "stays empty after release");
    summary();
    $finish;
  end
endmodule